// File: doc/BRIEF.md
# ATA Multiword DMA Handshake Engine

This block transfers 16-bit words between a host-side FIFO and an ATA device over the DMA request/acknowledge handshake. A one-cycle start command loads the direction and the number of words. The engine then pulls the active-low acknowledge low, which selects the device; both chip selects stay high for the whole transfer. It runs one read or write strobe cycle per word, and only while the device holds its request and the FIFO has room for a word or a word to send.

The strobe active width, the recovery width, the setup from acknowledge to first strobe and the hold from last strobe to release are separate programmable clock counts. When the request drops, the engine keeps the device selected and waits. An abort takes effect at the next word boundary. Completion is marked by a one-cycle done pulse together with a count of the words moved.

Top module: `ata_mwdma_engine`

## Requirements
- R1: After reset, dev_dack_n, dev_rd_n and dev_wr_n are 1, dev_cs_n is 2'b11, busy and done are 0 and words_done is 0.
- R2: A start pulse while idle pulls dev_dack_n low on the next clock edge and loads word_count and dir_wr (1 = write to the device). A start pulse while busy has no effect on the running transfer.
- R3: When request and FIFO are ready, the first strobe falls exactly max(t_ackset,1)+1 cycles after dev_dack_n falls.
- R4: Each strobe stays low exactly max(t_act,1) cycles. With the request held and the FIFO ready, the next strobe falls exactly max(t_rec,1)+1 cycles after the previous one rises.
- R5: Read (dir_wr=0): the word on dev_din at the clock edge where dev_rd_n rises appears on rx_data with a one-cycle rx_push in the next cycle. Words keep their order.
- R6: Write (dir_wr=1): tx_pop pulses once per word. dev_dout holds that word for the whole low phase of dev_wr_n, so the device receives the words in FIFO order.
- R7: No strobe starts while dev_dreq is 0. A strobe already running finishes, and dev_dack_n stays 0 until the transfer ends.
- R8: No strobe starts while rx_full is 1 (read) or tx_empty is 1 (write).
- R9: dev_cs_n stays 2'b11. dev_rd_n and dev_wr_n are never 0 together, and neither is 0 while dev_dack_n is 1.
- R10: After the last word, dev_dack_n rises exactly max(t_rec,1)+1+max(t_ackrel,1) cycles after the last strobe rises. done pulses for one cycle on that same edge, and words_done equals word_count.
- R11: An abort pulse during a transfer lets the running strobe finish and starts no further strobe. The engine then releases the device as in R10, and words_done counts only the finished words. An abort while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| dir_wr | input | 1 | 1 = write to the device, 0 = read from it |
| word_count | input | CW | Number of words to move |
| t_ackset | input | TW | Cycles from acknowledge to first strobe decision (0 counts as 1) |
| t_act | input | TW | Strobe low cycles (0 counts as 1) |
| t_rec | input | TW | Recovery cycles after each strobe (0 counts as 1) |
| t_ackrel | input | TW | Hold cycles before releasing the acknowledge (0 counts as 1) |
| abort | input | 1 | Stop the transfer at the next word boundary |
| tx_data | input | DW | Head word of the outgoing FIFO |
| tx_empty | input | 1 | Outgoing FIFO has no word |
| tx_pop | output | 1 | Take the head word of the outgoing FIFO |
| rx_data | output | DW | Word read from the device |
| rx_push | output | 1 | rx_data valid, write it into the incoming FIFO |
| rx_full | input | 1 | Incoming FIFO has no room |
| dev_dreq | input | 1 | Device DMA request |
| dev_dack_n | output | 1 | Active-low DMA acknowledge |
| dev_rd_n | output | 1 | Active-low read strobe |
| dev_wr_n | output | 1 | Active-low write strobe |
| dev_cs_n | output | 2 | Register-block chip selects, held inactive |
| dev_dout | output | DW | Data driven toward the device |
| dev_doe | output | 1 | Output enable for dev_dout |
| dev_din | input | DW | Data from the device |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| words_done | output | CW | Words finished in the current or last transfer |

## Verification
Two pairs of events can fall on the same clock edge. In the first, an abort arrives on the edge where the final word's strobe deasserts. The bench provokes this by timing the abort pulse from the observed fall of the last strobe. It expects the full word count, exactly one done pulse and a release of the acknowledge at the normal time. In the second, the request drops or the FIFO turns full or empty while a strobe is still low. The bench expects that strobe to finish and no new one to start, and it judges the transfer by the strobe count during the stall, by the acknowledge staying low, and by the scoreboard receiving every word in order once the stall ends.

// File: rtl/ata_mwdma_engine.sv
`timescale 1ns/1ps
module ata_mwdma_engine #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_wr,
  input  logic [CW-1:0] word_count,
  input  logic [TW-1:0] t_ackset,
  input  logic [TW-1:0] t_act,
  input  logic [TW-1:0] t_rec,
  input  logic [TW-1:0] t_ackrel,
  input  logic          abort,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_empty,
  output logic          tx_pop,
  output logic [DW-1:0] rx_data,
  output logic          rx_push,
  input  logic          rx_full,
  input  logic          dev_dreq,
  output logic          dev_dack_n,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic [1:0]    dev_cs_n,
  output logic [DW-1:0] dev_dout,
  output logic          dev_doe,
  input  logic [DW-1:0] dev_din,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] words_done
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_DECIDE, S_STROBE, S_RECOVER, S_HOLD} state_t;

  state_t        st;
  logic [TW-1:0] tcnt, lim, lim_e;
  logic [CW-1:0] left;
  logic          wr_q, stop_q, stop_now, ready, go, tick_end;

  always_comb begin
    case (st)
      S_SETUP:  lim = t_ackset;
      S_STROBE: lim = t_act;
      S_HOLD:   lim = t_ackrel;
      default:  lim = t_rec;
    endcase
  end

  assign lim_e    = (lim == '0) ? TW'(1) : lim;
  assign tick_end = (tcnt + TW'(1)) >= lim_e;
  assign ready    = wr_q ? !tx_empty : !rx_full;
  assign stop_now = stop_q || abort;
  assign go       = (st == S_DECIDE) && !stop_now && (left != '0) && dev_dreq && ready;

  assign tx_pop     = go && wr_q;
  assign busy       = (st != S_IDLE);
  assign dev_dack_n = (st == S_IDLE);
  assign dev_rd_n   = !((st == S_STROBE) && !wr_q);
  assign dev_wr_n   = !((st == S_STROBE) && wr_q);
  assign dev_cs_n   = 2'b11;
  assign dev_doe    = busy && wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tcnt       <= '0;
      left       <= '0;
      wr_q       <= 1'b0;
      stop_q     <= 1'b0;
      words_done <= '0;
      rx_data    <= '0;
      rx_push    <= 1'b0;
      dev_dout   <= '0;
      done       <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      done    <= 1'b0;
      if (abort && st != S_IDLE) stop_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st         <= S_SETUP;
          tcnt       <= '0;
          left       <= word_count;
          wr_q       <= dir_wr;
          words_done <= '0;
          stop_q     <= 1'b0;
        end
        S_SETUP: begin
          tcnt <= tick_end ? '0 : tcnt + TW'(1);
          if (tick_end) st <= S_DECIDE;
        end
        S_DECIDE: begin
          tcnt <= '0;
          if (stop_now || left == '0) st <= S_HOLD;
          else if (go) begin
            st <= S_STROBE;
            if (wr_q) dev_dout <= tx_data;
          end
        end
        S_STROBE: begin
          tcnt <= tick_end ? '0 : tcnt + TW'(1);
          if (tick_end) begin
            st         <= S_RECOVER;
            left       <= left - CW'(1);
            words_done <= words_done + CW'(1);
            if (!wr_q) begin
              rx_data <= dev_din;
              rx_push <= 1'b1;
            end
          end
        end
        S_RECOVER: begin
          tcnt <= tick_end ? '0 : tcnt + TW'(1);
          if (tick_end) st <= S_DECIDE;
        end
        S_HOLD: begin
          tcnt <= tick_end ? '0 : tcnt + TW'(1);
          if (tick_end) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            stop_q <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> (!dev_dack_n && (dev_rd_n || dev_wr_n)));

  assert_no_strobe_without_dreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dev_rd_n) || $fell(dev_wr_n)) |-> $past(dev_dreq));

  assert_no_read_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_rd_n) |-> !$past(rx_full));

  assert_no_write_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_wr_n) |-> !$past(tx_empty));

  assert_write_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_wr_n && $past(!dev_wr_n)) |-> $stable(dev_dout));

  assert_push_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (dev_rd_n && $past(!dev_rd_n)));

  assert_done_releases_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dev_dack_n && $past(!dev_dack_n)));

endmodule

// File: tb/sim_ata_mwdma_engine.sv
`timescale 1ns/1ps
module sim_ata_mwdma_engine;
  logic clk = 0, rst_n = 0;
  logic start = 0, dir_wr = 0, abort = 0, tx_empty = 0, rx_full = 0, dev_dreq = 0;
  logic [15:0] word_count = 0;
  logic [7:0] t_ackset = 2, t_act = 3, t_rec = 2, t_ackrel = 2;
  logic [15:0] tx_data, rx_data, dev_dout, dev_din, words_done;
  logic tx_pop, rx_push, dev_dack_n, dev_rd_n, dev_wr_n, dev_doe, busy, done;
  logic [1:0] dev_cs_n;

  int rd_idx = 0, tx_idx = 0, cyc = 0;
  int nchk = 0, nfail = 0;
  logic [15:0] exp_q[$];

  assign dev_din = 16'hA000 + 16'(rd_idx);
  assign tx_data = 16'hB000 + 16'(tx_idx);

  ata_mwdma_engine u0 (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rst_n && tx_pop) tx_idx <= tx_idx + 1;
  always @(posedge dev_rd_n) if (rst_n) rd_idx = rd_idx + 1;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int n_strobe, bad_width, cur_w, exp_act, min_gap, max_gap, viol, push_cnt, n_done;
  int t_dack_fall, t_first, t_last_rise, t_dack_rise;
  bit first_pend, p_dack = 1, p_s = 0, p_dreq = 0, p_full = 0, p_empty = 0;

  task automatic clear_stats(input int act_eff);
    n_strobe = 0; bad_width = 0; cur_w = 0; exp_act = act_eff;
    min_gap = 99999; max_gap = 0; viol = 0; push_cnt = 0; n_done = 0;
    first_pend = 0;
  endtask

  always @(negedge clk) begin
    bit s;
    s = !dev_rd_n || !dev_wr_n;
    if (rst_n) begin
      if (!dev_dack_n && p_dack) begin t_dack_fall = cyc; first_pend = 1; end
      if (s && !p_s) begin
        n_strobe++;
        if (first_pend) begin t_first = cyc; first_pend = 0; end
        else begin
          if (cyc - t_last_rise < min_gap) min_gap = cyc - t_last_rise;
          if (cyc - t_last_rise > max_gap) max_gap = cyc - t_last_rise;
        end
        if (!p_dreq) viol++;
        if (!dev_wr_n ? p_empty : p_full) viol++;
        cur_w = 0;
      end
      if (s) cur_w++;
      if (!s && p_s) begin t_last_rise = cyc; if (cur_w != exp_act) bad_width++; end
      if (dev_dack_n && !p_dack) t_dack_rise = cyc;
      if (done) n_done++;
      if (rx_push) begin
        push_cnt++;
        if (exp_q.size() == 0) chk("R5 read scoreboard underflow", 1, 0);
        else chk("R5 read word", int'(rx_data), int'(exp_q.pop_front()));
      end
    end
    p_dack = dev_dack_n; p_s = s; p_dreq = dev_dreq; p_full = rx_full; p_empty = tx_empty;
  end

  always @(posedge dev_wr_n) if (rst_n) begin
    if (exp_q.size() == 0) chk("R6 write scoreboard underflow", 1, 0);
    else chk("R6 write word", int'(dev_dout), int'(exp_q.pop_front()));
  end

  task automatic drive_start(input bit wr, input int n);
    @(posedge clk); #4;
    start = 1; dir_wr = wr; word_count = 16'(n);
    @(posedge clk); #4;
    start = 0;
  endtask

  task automatic launch(input bit wr, input int n, input int act_eff);
    clear_stats(act_eff);
    rd_idx = 0; tx_idx = 0;
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back(wr ? 16'hB000 + 16'(i) : 16'hA000 + 16'(i));
    drive_start(wr, n);
  endtask

  task automatic wait_done;
    for (int i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
    chk("R10 done seen", n_done, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_strobes(input int k);
    for (int i = 0; i < 3000 && n_strobe < k; i++) @(negedge clk);
  endtask

  task automatic pulse_abort;
    @(posedge clk); #4 abort = 1;
    @(posedge clk); #4 abort = 0;
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #4 rst_n = 1;
    @(negedge clk);
    chk("R1 dack_n", dev_dack_n, 1);
    chk("R1 rd_n", dev_rd_n, 1);
    chk("R1 wr_n", dev_wr_n, 1);
    chk("R1 cs_n", dev_cs_n, 3);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 words_done", words_done, 0);

    dev_dreq = 1;
    launch(0, 4, 3);
    @(negedge clk);
    chk("R2 dack after start", dev_dack_n, 0);
    chk("R9 cs_n during dma", dev_cs_n, 3);
    wait_done;
    chk("R3 ack to first strobe", t_first - t_dack_fall, 3);
    chk("R4 strobe width", bad_width, 0);
    chk("R4 min recovery gap", min_gap, 3);
    chk("R4 max recovery gap", max_gap, 3);
    chk("R10 release delay", t_dack_rise - t_last_rise, 5);
    chk("R10 words_done", words_done, 4);
    chk("R5 pushes", push_cnt, 4);
    chk("R5 queue drained", exp_q.size(), 0);
    chk("R7 R8 violations", viol, 0);

    launch(1, 5, 3);
    wait_done;
    chk("R6 queue drained", exp_q.size(), 0);
    chk("R6 words_done", words_done, 5);
    chk("R4 write strobe width", bad_width, 0);
    chk("R6 pops", tx_idx, 5);

    t_ackset = 0; t_act = 0; t_rec = 0; t_ackrel = 0;
    launch(0, 3, 1);
    wait_done;
    chk("R3 zero setup", t_first - t_dack_fall, 2);
    chk("R4 zero width", bad_width, 0);
    chk("R4 zero gap", max_gap, 2);
    chk("R10 zero release", t_dack_rise - t_last_rise, 3);
    t_ackset = 2; t_act = 3; t_rec = 2; t_ackrel = 2;

    launch(0, 6, 3);
    wait_strobes(2);
    @(posedge clk); #4 dev_dreq = 0;
    repeat (12) @(negedge clk);
    chk("R7 no strobe while dreq low", n_strobe, 2);
    chk("R7 ack held while paused", dev_dack_n, 0);
    @(posedge clk); #4 dev_dreq = 1;
    wait_done;
    chk("R7 words after pause", words_done, 6);
    chk("R7 queue drained", exp_q.size(), 0);
    chk("R7 violations", viol, 0);

    rx_full = 1;
    launch(0, 4, 3);
    repeat (15) @(negedge clk);
    chk("R8 no read while full", n_strobe, 0);
    chk("R8 ack held while full", dev_dack_n, 0);
    @(posedge clk); #4 rx_full = 0;
    wait_done;
    chk("R8 read words", words_done, 4);

    tx_empty = 1;
    launch(1, 3, 3);
    repeat (15) @(negedge clk);
    chk("R8 no write while empty", n_strobe, 0);
    @(posedge clk); #4 tx_empty = 0;
    wait_done;
    chk("R8 write words", words_done, 3);
    chk("R8 write queue drained", exp_q.size(), 0);

    launch(0, 10, 3);
    wait_strobes(4);
    pulse_abort;
    wait_done;
    chk("R11 abort words_done", words_done, 4);
    chk("R11 abort pushes", push_cnt, 4);
    chk("R11 strobes after abort", n_strobe, 4);
    chk("R11 release after abort", t_dack_rise - t_last_rise, 5);
    exp_q.delete();

    launch(0, 2, 3);
    wait_strobes(2);
    @(posedge clk);
    @(posedge clk); #4 abort = 1;
    @(posedge clk); #4 abort = 0;
    wait_done;
    chk("R11 coincident abort words", words_done, 2);
    chk("R11 coincident abort pushes", push_cnt, 2);
    chk("R10 single done", n_done, 1);
    chk("R10 coincident release", t_dack_rise - t_last_rise, 5);

    launch(0, 3, 3);
    wait_strobes(1);
    drive_start(0, 7);
    wait_done;
    chk("R2 start while busy ignored", words_done, 3);
    chk("R2 pushes", push_cnt, 3);

    pulse_abort;
    repeat (3) @(negedge clk);
    chk("R11 idle abort keeps ack", dev_dack_n, 1);
    launch(0, 2, 3);
    wait_done;
    chk("R11 idle abort ignored", words_done, 2);
    chk("R5 queue after idle abort", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule